// File: doc/BRIEF.md
# Four-Register Instruction Executor

This block executes a stream of pre-decoded instructions against a file of four 32-bit general registers. Each instruction has four fields: a 4-bit operation code and three operand fields, A, B and C. The result always lands in the register selected by C. The operations are add, multiply, bitwise AND, bitwise OR, copy, greater-than and equality. Each one reads its operands either from registers or as literals, depending on the operation code.

Instructions are offered with a valid/ready handshake. Every accepted instruction retires in the cycle it is accepted, so a dependent instruction can follow on the next cycle with no stall. Any field that an operation uses as a register index must be below four. If one is not, the instruction is discarded and a sticky fault flag is raised. All four registers are visible on an output bus. A synchronous clear input zeroes them.

Top module: `toy_exec`

## Requirements
- R1: After reset all four registers read zero, `fault_o` is low and `instr_ready_o` is high.
- R2: Operation codes decode as follows. Notation: rA and rB mean the register selected by field A or B; A and B alone mean the literal field value.
  - 0: C = (A == rB)
  - 1: C = A
  - 2: C = (rA == B)
  - 3: C = (rA == rB)
  - 4: C = rA + B
  - 5: C = rA
  - 6: C = (rA > rB)
  - 7: C = (rA > B)
  - 8: C = rA * B
  - 9: C = rA | B
  - 10: C = rA & B
  - 11: C = rA | rB
  - 12: C = (A > rB)
  - 13: C = rA & rB
  - 14: C = rA + rB
  - 15: C = rA * rB
- R3: Add and multiply are unsigned and wrap modulo 2^32, in both the register and the literal forms.
- R4: AND and OR act bitwise on 32-bit values, in both the register and the literal forms.
- R5: Codes 1 and 5 ignore field B entirely, including values of B of four or more.
- R6: Compares are unsigned. They write exactly 1 when the relation holds and 0 otherwise.
- R7: Field C, and every field that the code uses as a register index, must be below 4. If any is not, no register changes and `fault_o` goes high on the next cycle. Literal fields may take any 32-bit value without a fault.
- R8: `fault_o` stays high until reset. `clear_i` does not lower it. Valid instructions that arrive after a fault still execute.
- R9: A result is written on the clock edge that accepts the instruction. An instruction accepted on the following cycle reads the new value.
- R10: `clear_i` zeroes all registers on the next edge. An instruction offered in the same cycle is discarded and cannot raise the fault.
- R11: In a cycle with `instr_valid_i` low and `clear_i` low, the registers and the fault flag keep their values, whatever the fields hold.
- R12: `instr_ready_o` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the register file |
| instr_valid_i | input | 1 | Instruction offered |
| instr_ready_o | output | 1 | Instruction can be accepted |
| opcode_i | input | 4 | Operation code |
| field_a_i | input | 32 | Operand field A (register index or literal) |
| field_b_i | input | 32 | Operand field B (register index or literal) |
| field_c_i | input | 32 | Destination register index |
| regs_o | output | 128 | Register file, register k in bits [32k+31:32k] |
| fault_o | output | 1 | Sticky invalid-index flag |

## Verification
The hardest case to reach is the equality compare against a literal, because random operands almost never make that relation hold. The stimulus forces it. Before each instruction, copy-literal instructions load every register. The literal field of each compare is then often set to the current value of the register it will be compared with. All 64 index combinations of A, B and C are swept for each of the 16 codes, and the register contents are seeded with all-ones values so that add and multiply wrap. A second sweep drives an out-of-range value, both 4 and a large value, into each index field of each code in turn.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int OP_W = 4;

  typedef enum logic [2:0] {
    FN_ADD, FN_MUL, FN_AND, FN_OR, FN_CPY, FN_GT, FN_EQ
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e fn;
    logic    a_reg;   // A selects a register, else literal
    logic    b_reg;   // B selects a register, else literal
    logic    b_used;  // B takes part in the operation
  } dec_t;

  localparam logic [OP_W-1:0] OP_EQ_IR  = 4'd0;
  localparam logic [OP_W-1:0] OP_CPY_I  = 4'd1;
  localparam logic [OP_W-1:0] OP_EQ_RI  = 4'd2;
  localparam logic [OP_W-1:0] OP_EQ_RR  = 4'd3;
  localparam logic [OP_W-1:0] OP_ADD_RI = 4'd4;
  localparam logic [OP_W-1:0] OP_CPY_R  = 4'd5;
  localparam logic [OP_W-1:0] OP_GT_RR  = 4'd6;
  localparam logic [OP_W-1:0] OP_GT_RI  = 4'd7;
  localparam logic [OP_W-1:0] OP_MUL_RI = 4'd8;
  localparam logic [OP_W-1:0] OP_OR_RI  = 4'd9;
  localparam logic [OP_W-1:0] OP_AND_RI = 4'd10;
  localparam logic [OP_W-1:0] OP_OR_RR  = 4'd11;
  localparam logic [OP_W-1:0] OP_GT_IR  = 4'd12;
  localparam logic [OP_W-1:0] OP_AND_RR = 4'd13;
  localparam logic [OP_W-1:0] OP_ADD_RR = 4'd14;
  localparam logic [OP_W-1:0] OP_MUL_RR = 4'd15;
endpackage

// File: rtl/tx_decode.sv
module tx_decode
  import tx_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output dec_t            dec_o
);
  always_comb begin
    dec_o = '{fn: FN_CPY, a_reg: 1'b0, b_reg: 1'b0, b_used: 1'b0};
    unique case (opcode_i)
      OP_EQ_IR:  dec_o = '{fn: FN_EQ,  a_reg: 1'b0, b_reg: 1'b1, b_used: 1'b1};
      OP_CPY_I:  dec_o = '{fn: FN_CPY, a_reg: 1'b0, b_reg: 1'b0, b_used: 1'b0};
      OP_EQ_RI:  dec_o = '{fn: FN_EQ,  a_reg: 1'b1, b_reg: 1'b0, b_used: 1'b1};
      OP_EQ_RR:  dec_o = '{fn: FN_EQ,  a_reg: 1'b1, b_reg: 1'b1, b_used: 1'b1};
      OP_ADD_RI: dec_o = '{fn: FN_ADD, a_reg: 1'b1, b_reg: 1'b0, b_used: 1'b1};
      OP_CPY_R:  dec_o = '{fn: FN_CPY, a_reg: 1'b1, b_reg: 1'b0, b_used: 1'b0};
      OP_GT_RR:  dec_o = '{fn: FN_GT,  a_reg: 1'b1, b_reg: 1'b1, b_used: 1'b1};
      OP_GT_RI:  dec_o = '{fn: FN_GT,  a_reg: 1'b1, b_reg: 1'b0, b_used: 1'b1};
      OP_MUL_RI: dec_o = '{fn: FN_MUL, a_reg: 1'b1, b_reg: 1'b0, b_used: 1'b1};
      OP_OR_RI:  dec_o = '{fn: FN_OR,  a_reg: 1'b1, b_reg: 1'b0, b_used: 1'b1};
      OP_AND_RI: dec_o = '{fn: FN_AND, a_reg: 1'b1, b_reg: 1'b0, b_used: 1'b1};
      OP_OR_RR:  dec_o = '{fn: FN_OR,  a_reg: 1'b1, b_reg: 1'b1, b_used: 1'b1};
      OP_GT_IR:  dec_o = '{fn: FN_GT,  a_reg: 1'b0, b_reg: 1'b1, b_used: 1'b1};
      OP_AND_RR: dec_o = '{fn: FN_AND, a_reg: 1'b1, b_reg: 1'b1, b_used: 1'b1};
      OP_ADD_RR: dec_o = '{fn: FN_ADD, a_reg: 1'b1, b_reg: 1'b1, b_used: 1'b1};
      OP_MUL_RR: dec_o = '{fn: FN_MUL, a_reg: 1'b1, b_reg: 1'b1, b_used: 1'b1};
      default:   dec_o = '{fn: FN_CPY, a_reg: 1'b0, b_reg: 1'b0, b_used: 1'b0};
    endcase
  end
endmodule

// File: rtl/tx_alu.sv
module tx_alu
  import tx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_fn_e           fn_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (fn_i)
      FN_ADD:  res_o = x_i + y_i;
      FN_MUL:  res_o = x_i * y_i;
      FN_AND:  res_o = x_i & y_i;
      FN_OR:   res_o = x_i | y_i;
      FN_GT:   res_o = {{(DATA_W-1){1'b0}}, (x_i > y_i)};
      FN_EQ:   res_o = {{(DATA_W-1){1'b0}}, (x_i == y_i)};
      default: res_o = x_i;
    endcase
  end
endmodule

// File: rtl/tx_regfile.sv
module tx_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 4,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             wsel_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [NREGS-1:0][DATA_W-1:0] rdata_o
);
  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   rdata_o[k] <= '0;
      else if (clr_i)                                rdata_o[k] <= '0;
      else if (we_i && (wsel_i == IDX_W'(k)))        rdata_o[k] <= wdata_i;
    end
  end
endmodule

// File: rtl/toy_exec.sv
module toy_exec
  import tx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 4,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    instr_valid_i,
  output logic                    instr_ready_o,
  input  logic [OP_W-1:0]         opcode_i,
  input  logic [DATA_W-1:0]       field_a_i,
  input  logic [DATA_W-1:0]       field_b_i,
  input  logic [DATA_W-1:0]       field_c_i,
  output logic [NREGS*DATA_W-1:0] regs_o,
  output logic                    fault_o
);
  dec_t                         dec;
  logic [NREGS-1:0][DATA_W-1:0] rf;
  logic [DATA_W-1:0]            x_op, y_op, res;
  logic                         a_ok, b_ok, c_ok, idx_bad, accept, we;
  logic                         fault_q;

  tx_decode u_dec (.opcode_i(opcode_i), .dec_o(dec));

  assign a_ok    = field_a_i < DATA_W'(NREGS);
  assign b_ok    = field_b_i < DATA_W'(NREGS);
  assign c_ok    = field_c_i < DATA_W'(NREGS);
  assign idx_bad = !c_ok || (dec.a_reg && !a_ok) || (dec.b_used && dec.b_reg && !b_ok);

  assign instr_ready_o = 1'b1;
  assign accept        = instr_valid_i && instr_ready_o && !clear_i;
  assign we            = accept && !idx_bad;

  // register reads use only the low index bits; validity is checked above
  assign x_op = dec.a_reg ? rf[field_a_i[IDX_W-1:0]] : field_a_i;
  assign y_op = dec.b_reg ? rf[field_b_i[IDX_W-1:0]] : field_b_i;

  tx_alu #(.DATA_W(DATA_W)) u_alu (
    .fn_i (dec.fn),
    .x_i  (x_op),
    .y_i  (y_op),
    .res_o(res)
  );

  tx_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_i),
    .we_i   (we),
    .wsel_i (field_c_i[IDX_W-1:0]),
    .wdata_i(res),
    .rdata_o(rf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                fault_q <= 1'b0;
    else if (accept && idx_bad) fault_q <= 1'b1;
  end

  assign fault_o = fault_q;
  assign regs_o  = rf;
endmodule

// File: rtl/toy_exec_chk.sv
module toy_exec_chk
  import tx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    clear_i,
  input logic                    instr_valid_i,
  input logic                    instr_ready_o,
  input logic [OP_W-1:0]         opcode_i,
  input logic [DATA_W-1:0]       field_a_i,
  input logic [DATA_W-1:0]       field_c_i,
  input logic [NREGS*DATA_W-1:0] regs_o,
  input logic                    fault_o
);
  p_fault_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  p_fault_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(instr_valid_i) && !$past(clear_i));

  p_clear_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (regs_o == '0));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!instr_valid_i && !clear_i) |=> ($stable(regs_o) && $stable(fault_o)));

  p_copy_lit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_ready_o && !clear_i && opcode_i == 4'd1 && field_c_i == '0)
    |=> (regs_o[DATA_W-1:0] == $past(field_a_i)));

  p_bad_dest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !clear_i && field_c_i >= DATA_W'(NREGS))
    |=> (fault_o && $stable(regs_o)));

  p_ready_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_ready_o);
endmodule

bind toy_exec toy_exec_chk #(.DATA_W(DATA_W), .NREGS(NREGS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .instr_valid_i(instr_valid_i),
  .instr_ready_o(instr_ready_o),
  .opcode_i     (opcode_i),
  .field_a_i    (field_a_i),
  .field_c_i    (field_c_i),
  .regs_o       (regs_o),
  .fault_o      (fault_o)
);

// File: tb/test_toy_exec.sv
`timescale 1ns/1ps
module test_toy_exec;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic         vld = 1'b0;
  logic         rdy;
  logic [3:0]   op = '0;
  logic [31:0]  fa = '0, fb = '0, fc = '0;
  logic [127:0] regs;
  logic         fault;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] m_reg [4];
  logic        m_fault;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  toy_exec i_toy_exec (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .instr_valid_i(vld),
    .instr_ready_o(rdy), .opcode_i(op), .field_a_i(fa), .field_b_i(fb),
    .field_c_i(fc), .regs_o(regs), .fault_o(fault)
  );

  function automatic logic [31:0] nxt();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // index roles from R2
  function automatic bit a_idx(input int o);
    return !(o == 0 || o == 1 || o == 12);
  endfunction
  function automatic bit b_idx(input int o);
    return (o == 0 || o == 3 || o == 6 || o == 11 || o == 12 || o == 13 || o == 14 || o == 15);
  endfunction

  function automatic string tag_of(input int o);
    case (o)
      4, 8, 14, 15:  return "R3";
      9, 10, 11, 13: return "R4";
      1, 5:          return "R5";
      default:       return "R6";
    endcase
  endfunction

  function automatic void model(input int o, input logic [31:0] a, b, c);
    logic [31:0] x, y, r;
    if (c >= 4 || (a_idx(o) && a >= 4) || (b_idx(o) && b >= 4)) begin
      m_fault = 1'b1;
      return;
    end
    x = a_idx(o) ? m_reg[a[1:0]] : a;
    y = b_idx(o) ? m_reg[b[1:0]] : b;
    case (o)
      4, 14:            r = x + y;
      8, 15:            r = x * y;
      10, 13:           r = x & y;
      9, 11:            r = x | y;
      1, 5:             r = x;
      6, 7, 12:         r = (x > y) ? 32'd1 : 32'd0;
      default:          r = (x == y) ? 32'd1 : 32'd0;
    endcase
    m_reg[c[1:0]] = r;
  endfunction

  function automatic logic [127:0] m_vec();
    return {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
  endfunction

  task automatic check(input bit ok, input string what, input logic [128:0] act, exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  task automatic check_state(input string what);
    check(regs == m_vec() && fault == m_fault, what, {fault, regs}, {m_fault, m_vec()});
  endtask

  task automatic exec(input int o, input logic [31:0] a, b, c);
    @(negedge clk);
    op = 4'(o); fa = a; fb = b; fc = c; vld = 1'b1;
    model(o, a, b, c);
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    foreach (m_reg[k]) m_reg[k] = '0;
    m_fault = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    do_reset();
    check_state("R1 reset state");
    check(rdy == 1'b1, "R1 R12 ready after reset", {128'b0, rdy}, 129'd1);

    // R2..R6 sweep of every code over all index combinations
    for (int o = 0; o < 16; o++) begin
      for (int cb = 0; cb < 64; cb++) begin
        for (int k = 0; k < 4; k++)
          exec(1, ((cb + k) % 5 == 0) ? 32'hFFFF_FFFF : nxt(), nxt(), 32'(k));
        a = a_idx(o) ? 32'(cb % 4) : ((cb % 3 == 0) ? m_reg[(cb / 4) % 4] : nxt());
        b = b_idx(o) ? 32'((cb / 4) % 4) : ((cb % 3 == 1) ? m_reg[cb % 4] : nxt());
        exec(o, a, b, 32'(cb / 16));
        check_state($sformatf("R2 %s code %0d combo %0d", tag_of(o), o, cb));
        check(rdy == 1'b1, "R12 ready", {128'b0, rdy}, 129'd1);
      end
    end

    // R9 dependent instructions on consecutive cycles
    @(negedge clk);
    op = 4'd1; fa = 32'd5; fb = 32'd99; fc = 32'd0; vld = 1'b1; model(1, 5, 99, 0);
    @(negedge clk);
    op = 4'd4; fa = 32'd0; fb = 32'd7; fc = 32'd1; model(4, 0, 7, 1);
    @(negedge clk);
    op = 4'd15; fa = 32'd1; fb = 32'd1; fc = 32'd2; model(15, 1, 1, 2);
    @(negedge clk);
    vld = 1'b0;
    check_state("R9 back-to-back chain");
    check(regs[95:64] == 32'd144, "R9 chained product", {97'b0, regs[95:64]}, 129'd144);

    // R11 idle cycle with garbage fields
    @(negedge clk);
    op = 4'd1; fa = 32'hDEAD_BEEF; fc = 32'd3; vld = 1'b0;
    @(negedge clk);
    check_state("R11 valid low leaves state");

    // R10 clear beats a simultaneous faulting instruction
    @(negedge clk);
    clear = 1'b1; vld = 1'b1; op = 4'd1; fa = 32'd1; fc = 32'd9;
    @(negedge clk);
    clear = 1'b0; vld = 1'b0;
    foreach (m_reg[k]) m_reg[k] = '0;
    check_state("R10 clear with instruction offered");

    // R7 invalid index in each used index field
    for (int o = 0; o < 16; o++) begin
      for (int f = 0; f < 3; f++) begin
        if ((f == 0 && !a_idx(o)) || (f == 1 && !b_idx(o))) continue;
        for (int k = 0; k < 4; k++) exec(1, nxt(), 32'd0, 32'(k));
        a = (f == 0) ? ((o % 2 == 0) ? 32'd4 : 32'h8000_0000) : 32'd1;
        b = (f == 1) ? ((o % 2 == 0) ? 32'h8000_0000 : 32'd4) : 32'd2;
        exec(o, a, b, (f == 2) ? 32'd4 + 32'(o) : 32'd3);
        check_state($sformatf("R7 code %0d bad field %0d", o, f));
      end
    end

    // R8 fault stays, later instructions still run, clear leaves it
    exec(4, 32'd3, 32'd11, 32'd0);
    check_state("R8 execute after fault");
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    foreach (m_reg[k]) m_reg[k] = '0;
    check_state("R8 fault survives clear");

    do_reset();
    check_state("R1 reset lowers fault");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule